// File: doc/BRIEF.md
# Hardware Return Address Stack

This block is the private return-address store of a processor core. It keeps a last-in, first-out list of program-counter values in storage that sits outside both program and data memory. The core pushes the current PC when it takes a call, a relative call or an interrupt, and pops it on any of its three return forms. The value now on top is always presented on `tos_o`, so the core can load its PC from it in the same cycle it pops.

Software sees the stack through four byte-wide registers. Three of them hold the top entry, one byte each. The fourth holds the level pointer and two sticky error flags. Software can also push or pop through separate strobes. A software push stores `pc_i` exactly as a core push does, and software then overwrites the new top entry through the byte registers. Level 0 means the stack is empty, so the usable levels are 1 to 2^PTR_W−1.

Top module: `ret_addr_stack`

## Requirements
- R1: After a synchronous reset the level pointer is 0, both flags are 0, `tos_o` is 0 and `reg_rdata_o` is 0.
- R2: A push (`push_i` or `sw_push_i`) below the full level raises the pointer by one and stores `pc_i` at the new level. From the next cycle `tos_o` shows that value.
- R3: A push at the full level (2^PTR_W−1) sets the overflow flag. It leaves the pointer and every stored entry unchanged.
- R4: A pop (`pop_i` or `sw_pop_i`) above level 0 lowers the pointer by one. From the next cycle `tos_o` shows the entry one level down, so entries come back in reverse order of pushing.
- R5: A pop at level 0 sets the underflow flag and leaves the pointer at 0. While the pointer is 0, `tos_o` reads 0.
- R6: At most one stack operation takes effect per cycle. The order of precedence is core push, then core pop, then software push, then software pop.
- R7: A register write (`reg_wr_i`) in a cycle where any push or pop strobe is high is ignored.
- R8: `reg_rdata_o` is registered and shows, one cycle later, the register selected by `reg_addr_i`. Address 0 gives top bits 7:0, address 1 gives bits 15:8, address 2 gives bits 23:16 of the zero-extended top entry, and address 3 gives the status register. In the status register, bit 7 is overflow, bit 6 is underflow, bits PTR_W−1:0 hold the pointer, and all other bits are 0.
- R9: A write to address 0, 1 or 2 replaces that byte of the top entry and leaves its other bytes unchanged. When the pointer is 0 the write has no effect.
- R10: A write to address 3 loads the pointer from bits PTR_W−1:0. Writing 0 to bit 7 or bit 6 clears that flag; writing 1 leaves it unchanged.
- R11: Once set, a flag stays set through any later pushes, pops and other register writes until software clears it as R10 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Core push strobe (call or interrupt) |
| pop_i | input | 1 | Core pop strobe (any return) |
| pc_i | input | AW | Value stored by a push |
| sw_push_i | input | 1 | Software push strobe |
| sw_pop_i | input | 1 | Software pop strobe |
| tos_o | output | AW | Current top entry, 0 when empty |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the stack with PTR_W = 3, which gives seven levels. With that depth, a few pushes reach the full level, so overflow, the sticky flags and the underflow that follows can be tested within a short run. AW stays at 21, so the upper top-of-stack byte keeps its 5-bit zero-extended form and the byte merges in R9 cover all three lanes. The behavioural model also covers strobe collisions, pointer reloads into levels that already hold data, and byte writes on an empty stack.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_REG  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    RA_TOS_B0 = 2'd0,
    RA_TOS_B1 = 2'd1,
    RA_TOS_B2 = 2'd2,
    RA_STATUS = 2'd3
  } reg_sel_e;

  localparam int EXT_W   = 24;
  localparam int OVF_BIT = 7;
  localparam int UNF_BIT = 6;

  // Precedence: core push, core pop, software push, software pop, register write
  function automatic stk_op_e pick_op(input logic cpush, input logic cpop,
                                      input logic spush, input logic spop,
                                      input logic rwr);
    if (cpush)      return OP_PUSH;
    else if (cpop)  return OP_POP;
    else if (spush) return OP_PUSH;
    else if (spop)  return OP_POP;
    else if (rwr)   return OP_REG;
    else            return OP_NONE;
  endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl import ras_pkg::*; #(
  parameter int PTR_W = 5,
  parameter int AW    = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             sw_push_i,
  input  logic             sw_pop_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic [AW-1:0]    tos_cur_i,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] ptr_nxt,
  output logic             ovf_q,
  output logic             unf_q,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_wa,
  output logic [AW-1:0]    mem_wd
);
  localparam logic [PTR_W-1:0] FULL  = '1;
  localparam logic [PTR_W-1:0] EMPTY = '0;

  stk_op_e          op;
  logic             ovf_n, unf_n;
  logic [EXT_W-1:0] ext;

  always_comb begin
    op      = pick_op(push_i, pop_i, sw_push_i, sw_pop_i, reg_wr_i);
    ptr_nxt = ptr_q;
    ovf_n   = ovf_q;
    unf_n   = unf_q;
    mem_we  = 1'b0;
    mem_wa  = ptr_q;
    ext     = EXT_W'(tos_cur_i);
    case (op)
      OP_PUSH: begin
        if (ptr_q == FULL) begin
          ovf_n = 1'b1;
        end else begin
          ptr_nxt = ptr_q + 1'b1;
          mem_we  = 1'b1;
          mem_wa  = ptr_q + 1'b1;
          ext     = EXT_W'(pc_i);
        end
      end
      OP_POP: begin
        if (ptr_q == EMPTY) unf_n = 1'b1;
        else                ptr_nxt = ptr_q - 1'b1;
      end
      OP_REG: begin
        case (reg_sel_e'(reg_addr_i))
          RA_TOS_B0: begin ext[7:0]   = reg_wdata_i; mem_we = (ptr_q != EMPTY); end
          RA_TOS_B1: begin ext[15:8]  = reg_wdata_i; mem_we = (ptr_q != EMPTY); end
          RA_TOS_B2: begin ext[23:16] = reg_wdata_i; mem_we = (ptr_q != EMPTY); end
          RA_STATUS: begin
            ptr_nxt = reg_wdata_i[PTR_W-1:0];
            ovf_n   = ovf_q & reg_wdata_i[OVF_BIT];
            unf_n   = unf_q & reg_wdata_i[UNF_BIT];
          end
          default: ;
        endcase
      end
      default: ;
    endcase
    mem_wd = ext[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ptr_q <= ptr_nxt;
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end
endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int PTR_W = 5,
  parameter int AW    = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] wa,
  input  logic [AW-1:0]    wd,
  input  logic [PTR_W-1:0] ra,
  output logic [AW-1:0]    rd_q
);
  localparam int SLOTS = 2 ** PTR_W;

  logic [AW-1:0] store [SLOTS];

  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end

  // Registered read with write-first forwarding
  always_ff @(posedge clk) begin
    if (rst)                rd_q <= '0;
    else if (we && wa == ra) rd_q <= wd;
    else                    rd_q <= store[ra];
  end
endmodule

// File: rtl/ras_rdmux.sv
module ras_rdmux import ras_pkg::*; #(
  parameter int PTR_W = 5,
  parameter int AW    = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr_i,
  input  logic [AW-1:0]    tos_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             ovf_i,
  input  logic             unf_i,
  output logic [7:0]       rdata_q
);
  logic [EXT_W-1:0] t;
  logic [7:0]       status, sel;

  always_comb begin
    t                 = EXT_W'(tos_i);
    status            = '0;
    status[PTR_W-1:0] = ptr_i;
    status[OVF_BIT]   = ovf_i;
    status[UNF_BIT]   = unf_i;
    case (reg_sel_e'(reg_addr_i))
      RA_TOS_B0: sel = t[7:0];
      RA_TOS_B1: sel = t[15:8];
      RA_TOS_B2: sel = t[23:16];
      default:   sel = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel;
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int PTR_W = 5,
  parameter int AW    = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] pc_i,
  input  logic          sw_push_i,
  input  logic          sw_pop_i,
  output logic [AW-1:0] tos_o,
  output logic          ovf_o,
  output logic          unf_o,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o
);
  logic [PTR_W-1:0] ptr_q, ptr_nxt, mem_wa;
  logic             ovf_q, unf_q, mem_we;
  logic [AW-1:0]    mem_wd, rd_q;

  ras_ctrl #(.PTR_W(PTR_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_i(push_i), .pop_i(pop_i), .sw_push_i(sw_push_i), .sw_pop_i(sw_pop_i),
    .pc_i(pc_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .tos_cur_i(tos_o),
    .ptr_q(ptr_q), .ptr_nxt(ptr_nxt), .ovf_q(ovf_q), .unf_q(unf_q),
    .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd)
  );

  ras_mem #(.PTR_W(PTR_W), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
    .ra(ptr_nxt), .rd_q(rd_q)
  );

  assign tos_o = (ptr_q == '0) ? '0 : rd_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  ras_rdmux #(.PTR_W(PTR_W), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .reg_addr_i(reg_addr_i), .tos_i(tos_o),
    .ptr_i(ptr_q), .ovf_i(ovf_q), .unf_i(unf_q), .rdata_q(reg_rdata_o)
  );
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int PTR_W = 5,
  parameter int AW    = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             push_i,
  input logic             pop_i,
  input logic             sw_push_i,
  input logic             sw_pop_i,
  input logic [AW-1:0]    pc_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic [PTR_W-1:0] ptr,
  input logic             ovf,
  input logic             unf,
  input logic [AW-1:0]    tos
);
  localparam logic [PTR_W-1:0] FULL = '1;

  logic any_op, stat_wr;
  assign any_op  = push_i | pop_i | sw_push_i | sw_pop_i;
  assign stat_wr = reg_wr_i && !any_op && reg_addr_i == 2'd3;

  assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
    (push_i && ptr != FULL) |=> (ptr == $past(ptr) + 1'b1 && tos == $past(pc_i)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (push_i && ptr == FULL) |=> (ovf && ptr == FULL && $stable(tos)));

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && ptr != '0) |=> (ptr == $past(ptr) - 1'b1));

  assert_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && ptr == '0) |=> (unf && ptr == '0 && tos == '0));

  assert_status_load_R10: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (ptr == $past(reg_wdata_i[PTR_W-1:0])));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf && !stat_wr) |=> ovf);

  assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (unf && !stat_wr) |=> unf);
endmodule

bind ret_addr_stack ras_chk #(.PTR_W(PTR_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
  .sw_push_i(sw_push_i), .sw_pop_i(sw_pop_i), .pc_i(pc_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .ptr(ptr_q), .ovf(ovf_q), .unf(unf_q), .tos(tos_o)
);

// File: tb/sim_ret_addr_stack.sv
`timescale 1ns/100ps
module sim_ret_addr_stack;
  localparam int PW = 3;
  localparam int AW = 21;
  localparam int DEPTH = 2 ** PW - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_i = 0, pop_i = 0, sw_push_i = 0, sw_pop_i = 0, reg_wr_i = 0;
  logic [AW-1:0] pc_i = '0;
  logic [1:0]    reg_addr_i = '0;
  logic [7:0]    reg_wdata_i = '0;
  logic [AW-1:0] tos_o;
  logic          ovf_o, unf_o;
  logic [7:0]    reg_rdata_o;

  always #2.5 clk = ~clk;

  ret_addr_stack #(.PTR_W(PW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
    .sw_push_i(sw_push_i), .sw_pop_i(sw_pop_i), .tos_o(tos_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  int     n_checks = 0, n_fail = 0, cycles = 0;
  string  cur_req = "R1";
  int     m_ptr = 0;
  bit     m_ovf = 0, m_unf = 0;
  logic [AW-1:0] m_mem [0:DEPTH];
  logic [7:0]    m_rd = '0;

  function automatic logic [AW-1:0] m_tos();
    return (m_ptr == 0) ? '0 : m_mem[m_ptr];
  endfunction

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
    end
  endtask

  // Behavioural model, updated at each edge, compared just after it
  always @(posedge clk) begin
    logic [23:0] t;
    logic [7:0]  s;
    cycles++;
    if (rst) begin
      m_ptr = 0; m_ovf = 0; m_unf = 0; m_rd = '0;
    end else begin
      t = 24'(m_tos());
      s = 8'(m_ptr);
      s[7] = m_ovf; s[6] = m_unf;
      case (reg_addr_i)
        2'd0: m_rd = t[7:0];
        2'd1: m_rd = t[15:8];
        2'd2: m_rd = t[23:16];
        default: m_rd = s;
      endcase
      if (push_i || (!pop_i && sw_push_i)) begin
        if (m_ptr == DEPTH) m_ovf = 1;
        else begin m_ptr++; m_mem[m_ptr] = pc_i; end
      end else if (pop_i || sw_pop_i) begin
        if (m_ptr == 0) m_unf = 1;
        else m_ptr--;
      end else if (reg_wr_i) begin
        if (reg_addr_i == 2'd3) begin
          m_ptr = int'(reg_wdata_i[PW-1:0]);
          m_ovf = m_ovf & reg_wdata_i[7];
          m_unf = m_unf & reg_wdata_i[6];
        end else if (m_ptr != 0) begin
          t = 24'(m_mem[m_ptr]);
          t[8*reg_addr_i +: 8] = reg_wdata_i;
          m_mem[m_ptr] = t[AW-1:0];
        end
      end
    end
    #1;
    chk("tos_o", 32'(tos_o), 32'(m_tos()));
    chk("ovf_o", 32'(ovf_o), 32'(m_ovf));
    chk("unf_o", 32'(unf_o), 32'(m_unf));
    chk("reg_rdata_o", 32'(reg_rdata_o), 32'(m_rd));
  end

  task automatic step(input bit p, input bit po, input bit sp, input bit spo,
                      input logic [AW-1:0] pc, input bit wr,
                      input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    push_i = p; pop_i = po; sw_push_i = sp; sw_pop_i = spo;
    pc_i = pc; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic idle(input logic [1:0] a);
    step(0, 0, 0, 0, '0, 0, a, 8'h00);
  endtask

  task automatic show_all();
    for (int a = 0; a < 4; a++) idle(2'(a));
  endtask

  initial begin
    for (int i = 0; i <= DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1"; idle(2'd3); idle(2'd0);
    chk("reset tos", 32'(tos_o), 32'h0);

    cur_req = "R2";
    step(1, 0, 0, 0, 21'h1A2B3C, 0, 2'd0, 0);
    step(0, 0, 1, 0, 21'h00F0F2, 0, 2'd3, 0);
    step(1, 0, 0, 0, 21'h1FFFFE, 0, 2'd2, 0);
    cur_req = "R8"; show_all();

    cur_req = "R4";
    step(0, 1, 0, 0, '0, 0, 2'd1, 0);
    step(0, 0, 0, 1, '0, 0, 2'd3, 0);
    idle(2'd0);

    cur_req = "R3";
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 0, 21'(32'h10000 + i * 32'h1357), 0, 2'd3, 0);
    step(0, 0, 1, 0, 21'h0ABCDE, 0, 2'd3, 0);
    idle(2'd3); idle(2'd0);

    cur_req = "R11";
    step(0, 1, 0, 0, '0, 0, 2'd3, 0);
    step(0, 0, 0, 0, '0, 1, 2'd0, 8'h5A);
    step(0, 0, 0, 0, '0, 1, 2'd3, 8'hC0 | 8'(DEPTH - 1));
    idle(2'd3);

    cur_req = "R5";
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, '0, 0, 2'd3, 0);
    step(0, 1, 0, 0, '0, 0, 2'd0, 0);
    idle(2'd3);

    cur_req = "R9";
    step(0, 0, 0, 0, '0, 1, 2'd1, 8'h77);
    idle(2'd1);
    step(1, 0, 0, 0, 21'h123456, 0, 2'd0, 0);
    step(0, 0, 0, 0, '0, 1, 2'd0, 8'hA5);
    step(0, 0, 0, 0, '0, 1, 2'd1, 8'h3C);
    step(0, 0, 0, 0, '0, 1, 2'd2, 8'hFF);
    show_all();

    cur_req = "R6";
    step(1, 1, 1, 1, 21'h0C0DE0, 0, 2'd3, 0);
    step(0, 1, 1, 1, 21'h0BEEF0, 0, 2'd3, 0);
    step(0, 0, 1, 1, 21'h055550, 0, 2'd3, 0);
    step(0, 0, 0, 1, '0, 0, 2'd0, 0);
    idle(2'd3);

    cur_req = "R7";
    step(1, 0, 0, 0, 21'h0AAAA0, 1, 2'd3, 8'h00);
    step(0, 1, 0, 0, '0, 1, 2'd0, 8'h11);
    step(0, 0, 0, 1, '0, 1, 2'd3, 8'h07);
    show_all();

    cur_req = "R10";
    step(0, 0, 0, 0, '0, 1, 2'd3, 8'h3F);
    idle(2'd3);
    step(0, 0, 0, 0, '0, 1, 2'd3, 8'h01);
    idle(2'd0);
    step(0, 0, 0, 0, '0, 1, 2'd3, 8'h00);
    idle(2'd3); idle(2'd3);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog got %0d cycles exp completion", cycles);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule